// File: doc/BRIEF.md
# Processor Core Power-Up Sequencer

This block is a hardware state machine that takes a secondary processor core out of power collapse. A single start request launches a fixed, timed series of steps. The core's memory array is unclamped first and its head-switch is closed. Then the output clamp opens. Last, both resets are released together and the core is declared powered. Each settling interval is a whole number of clock cycles, derived from a clock-frequency parameter and rounded up so that it never falls short of the microsecond figure.

The block drives two words. The first is an eight-bit core control vector whose bit positions are fixed by the neighbour that decodes them. The second is a 32-bit gate-control word that enables the power-gate head-switch and carries its step count. A busy flag covers the active sequence. A one-cycle done pulse marks the cycle in which the powered-up bit rises. Once the sequence has finished, the outputs hold their final values until a new start or a reset.

Top module: `core_pwrup_seq`

## Requirements
- R1: While `rst_ni` is low, and afterwards until a start is accepted, the core control vector reads 0x33 (output clamp bit 0, memory clamp bit 1, core reset bit 4 and power-on reset bit 5 set), the gate word reads 0, and busy and done are low.
- R2: A start sampled in the idle state produces, one cycle later, control vector 0x33 with busy high and the gate word still 0.
- R3: One cycle after that, the gate word becomes 0x1000_0001 (enable at bit 0, head-switch count 16 in bits 31:24) and keeps that value until the sequence ends and in the finished state.
- R4: The gate enable is held with vector 0x33 for exactly W = ceil(WAIT_US * CLK_FREQ_HZ / 1e6) cycles (400 at the defaults). After that only the memory clamp drops, giving 0x31 for one cycle.
- R5: The memory head-switch (bit 3) then closes, giving 0x39, which is held for exactly W cycles.
- R6: The output clamp then opens, giving 0x38, which is held for exactly W cycles.
- R7: Core reset and power-on reset are released in the same cycle, giving 0x08 for one cycle.
- R8: In the next cycle the powered-up bit (bit 7) sets, giving 0x88, and done pulses for that single cycle. From the following cycle busy is low and 0x88 holds.
- R9: Bit 2 (L1 reset-disable) and bit 6 (clock gate) of the control vector are low at all times.
- R10: A start that arrives while busy is ignored. The timeline of the sequence in progress is unchanged.
- R11: A start in the finished state runs the whole sequence again from the R2 step.
- R12: Asserting `rst_ni` in the middle of a sequence returns the outputs to the R1 state at once. A later start then runs a complete sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Request to run the power-up sequence |
| core_ctl_o | output | 8 | Core power-control vector (clamps, head-switch, resets, powered-up) |
| gate_ctl_o | output | 32 | Power-gate control word: enable bit 0, head-switch count bits 31:24 |
| busy_o | output | 1 | High while a sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the powered-up bit sets |

## Verification
The hardest situations to reach are a second start arriving in the middle of a long settling interval and a reset landing partway through a wait. In both, the damage would only show as a shifted or truncated timeline many cycles later. The stimulus pulses start while the memory head-switch interval is running, then compares every later step against the same cycle offsets used for an undisturbed run. It also drops reset during the first interval and then requires a complete, correctly timed sequence on the next start. Each wait is checked at its last held cycle and at its first changed cycle, so an off-by-one in the cycle count is caught.

// File: rtl/core_pwrup_pkg.sv
package core_pwrup_pkg;

  typedef enum logic [3:0] {
    PS_IDLE       = 4'd0,
    PS_CLAMP      = 4'd1,
    PS_GATE_WAIT  = 4'd2,
    PS_MCLAMP_OFF = 4'd3,
    PS_MHS_WAIT   = 4'd4,
    PS_OCLAMP_OFF = 4'd5,
    PS_RST_OFF    = 4'd6,
    PS_UP         = 4'd7,
    PS_DONE       = 4'd8
  } pwrup_state_e;

  localparam int unsigned CTL_W      = 8;
  localparam int unsigned BIT_OCLAMP = 0;
  localparam int unsigned BIT_MCLAMP = 1;
  localparam int unsigned BIT_L1RD   = 2;
  localparam int unsigned BIT_MHS    = 3;
  localparam int unsigned BIT_CRST   = 4;
  localparam int unsigned BIT_PRST   = 5;
  localparam int unsigned BIT_CGATE  = 6;
  localparam int unsigned BIT_UP     = 7;

  localparam int unsigned GATE_W       = 32;
  localparam int unsigned GATE_CNT_LSB = 24;
  localparam int unsigned GATE_CNT_W   = 8;

  // Cycles covering a microsecond interval, rounded up, never below one.
  function automatic int unsigned wait_cycles(longint unsigned freq_hz,
                                              longint unsigned usec);
    longint unsigned prod;
    longint unsigned cyc;
    prod = freq_hz * usec;
    cyc  = (prod + 64'd999_999) / 64'd1_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return int'(cyc[31:0]);
  endfunction

endpackage

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
  parameter int unsigned WAIT_CYC = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import core_pwrup_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         expired_i,
  output pwrup_state_e state_o,
  output logic         load_o
);
  pwrup_state_e state_q;
  pwrup_state_e state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    unique case (state_q)
      PS_IDLE:       if (start_i) state_d = PS_CLAMP;
      PS_CLAMP: begin
        state_d = PS_GATE_WAIT;
        load_o  = 1'b1;
      end
      PS_GATE_WAIT:  if (expired_i) state_d = PS_MCLAMP_OFF;
      PS_MCLAMP_OFF: begin
        state_d = PS_MHS_WAIT;
        load_o  = 1'b1;
      end
      PS_MHS_WAIT: begin
        if (expired_i) begin
          state_d = PS_OCLAMP_OFF;
          load_o  = 1'b1;
        end
      end
      PS_OCLAMP_OFF: if (expired_i) state_d = PS_RST_OFF;
      PS_RST_OFF:    state_d = PS_UP;
      PS_UP:         state_d = PS_DONE;
      PS_DONE:       if (start_i) state_d = PS_CLAMP;
      default:       state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/pwrup_out_map.sv
module pwrup_out_map
  import core_pwrup_pkg::*;
#(
  parameter int unsigned GATE_CNT = 16
) (
  input  pwrup_state_e      state_i,
  output logic [CTL_W-1:0]  core_ctl_o,
  output logic [GATE_W-1:0] gate_ctl_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [GATE_W-1:0] GATE_ON_WORD =
    (GATE_W'(GATE_CNT_W'(GATE_CNT)) << GATE_CNT_LSB) | GATE_W'(1);

  logic f_oclamp, f_mclamp, f_mhs, f_crst, f_prst, f_up, gate_on;

  always_comb begin
    f_oclamp = 1'b1;
    f_mclamp = 1'b1;
    f_mhs    = 1'b0;
    f_crst   = 1'b1;
    f_prst   = 1'b1;
    f_up     = 1'b0;
    gate_on  = 1'b1;
    busy_o   = 1'b1;
    done_o   = 1'b0;
    unique case (state_i)
      PS_IDLE: begin
        gate_on = 1'b0;
        busy_o  = 1'b0;
      end
      PS_CLAMP:      gate_on = 1'b0;
      PS_GATE_WAIT:  gate_on = 1'b1;
      PS_MCLAMP_OFF: f_mclamp = 1'b0;
      PS_MHS_WAIT: begin
        f_mclamp = 1'b0;
        f_mhs    = 1'b1;
      end
      PS_OCLAMP_OFF: begin
        f_mclamp = 1'b0;
        f_mhs    = 1'b1;
        f_oclamp = 1'b0;
      end
      PS_RST_OFF: begin
        f_mclamp = 1'b0;
        f_mhs    = 1'b1;
        f_oclamp = 1'b0;
        f_crst   = 1'b0;
        f_prst   = 1'b0;
      end
      PS_UP: begin
        f_mclamp = 1'b0;
        f_mhs    = 1'b1;
        f_oclamp = 1'b0;
        f_crst   = 1'b0;
        f_prst   = 1'b0;
        f_up     = 1'b1;
        done_o   = 1'b1;
      end
      PS_DONE: begin
        f_mclamp = 1'b0;
        f_mhs    = 1'b1;
        f_oclamp = 1'b0;
        f_crst   = 1'b0;
        f_prst   = 1'b0;
        f_up     = 1'b1;
        busy_o   = 1'b0;
      end
      default: begin
        gate_on = 1'b0;
        busy_o  = 1'b0;
      end
    endcase
  end

  always_comb begin
    core_ctl_o             = '0;
    core_ctl_o[BIT_OCLAMP] = f_oclamp;
    core_ctl_o[BIT_MCLAMP] = f_mclamp;
    core_ctl_o[BIT_L1RD]   = 1'b0;
    core_ctl_o[BIT_MHS]    = f_mhs;
    core_ctl_o[BIT_CRST]   = f_crst;
    core_ctl_o[BIT_PRST]   = f_prst;
    core_ctl_o[BIT_CGATE]  = 1'b0;
    core_ctl_o[BIT_UP]     = f_up;
  end

  assign gate_ctl_o = gate_on ? GATE_ON_WORD : '0;

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import core_pwrup_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned WAIT_US     = 2,
  parameter int unsigned GATE_CNT    = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic [7:0]  core_ctl_o,
  output logic [31:0] gate_ctl_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int unsigned WAIT_CYC = wait_cycles(64'(CLK_FREQ_HZ), 64'(WAIT_US));

  pwrup_state_e state;
  logic         tmr_load;
  logic         tmr_expired;

  pwrup_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .expired_i (tmr_expired),
    .state_o   (state),
    .load_o    (tmr_load)
  );

  pwrup_wait_timer #(
    .WAIT_CYC (WAIT_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .expired_o (tmr_expired)
  );

  pwrup_out_map #(
    .GATE_CNT (GATE_CNT)
  ) u_map (
    .state_i    (state),
    .core_ctl_o (core_ctl_o),
    .gate_ctl_o (gate_ctl_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

endmodule

// File: rtl/core_pwrup_chk.sv
module core_pwrup_chk
  import core_pwrup_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 200_000_000,
  parameter int unsigned WAIT_US     = 2,
  parameter int unsigned GATE_CNT    = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [7:0]  core_ctl_o,
  input logic [31:0] gate_ctl_o,
  input logic        busy_o,
  input logic        done_o
);
  localparam int unsigned W     = wait_cycles(64'(CLK_FREQ_HZ), 64'(WAIT_US));
  localparam int unsigned RUN_W = $clog2(W + 2);
  localparam logic [31:0] GATE_ON = (32'(GATE_CNT_W'(GATE_CNT)) << GATE_CNT_LSB) | 32'd1;

  logic [RUN_W-1:0] mhs_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mhs_run <= '0;
    else if (core_ctl_o == 8'h39) mhs_run <= mhs_run + 1'b1;
    else mhs_run <= '0;
  end

  assert_spare_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_ctl_o[2] == 1'b0) && (core_ctl_o[6] == 1'b0));

  assert_gate_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_ctl_o != 32'd0) |-> (gate_ctl_o == GATE_ON));

  assert_mclamp_after_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_ctl_o[1]) |-> (gate_ctl_o[0] && core_ctl_o[0]));

  assert_mhs_after_mclamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_ctl_o[3]) |-> (!core_ctl_o[1] && $past(!core_ctl_o[1])));

  assert_mhs_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(core_ctl_o) == 8'h39) && (core_ctl_o != 8'h39)) |-> (mhs_run == RUN_W'(W)));

  assert_oclamp_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_ctl_o[0]) |-> core_ctl_o[3]);

  assert_resets_together_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_ctl_o[4]) |-> $fell(core_ctl_o[5]));

  assert_done_with_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_ctl_o[7]) |-> done_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);

endmodule

bind core_pwrup_seq core_pwrup_chk #(
  .CLK_FREQ_HZ (CLK_FREQ_HZ),
  .WAIT_US     (WAIT_US),
  .GATE_CNT    (GATE_CNT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .core_ctl_o (core_ctl_o),
  .gate_ctl_o (gate_ctl_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/core_pwrup_seq_tb.sv
`timescale 1ns/1ps
module core_pwrup_seq_tb;
  localparam int unsigned FREQ = 200_000_000;
  localparam int unsigned WUS  = 2;
  localparam int W = (FREQ / 1000 * WUS + 999) / 1000;  // ceil -> 400
  localparam logic [31:0] G = 32'h1000_0001;
  localparam int NROWS = 11;

  typedef struct packed {
    logic [15:0] n;
    logic [7:0]  ctl;
    logic [31:0] gate;
    logic        busy;
    logic        done;
  } row_t;

  localparam row_t ROWS [NROWS] = '{
    '{16'(0),       8'h33, 32'h0, 1'b1, 1'b0},
    '{16'(1),       8'h33, G,     1'b1, 1'b0},
    '{16'(W),       8'h33, G,     1'b1, 1'b0},
    '{16'(W+1),     8'h31, G,     1'b1, 1'b0},
    '{16'(W+2),     8'h39, G,     1'b1, 1'b0},
    '{16'(2*W+1),   8'h39, G,     1'b1, 1'b0},
    '{16'(2*W+2),   8'h38, G,     1'b1, 1'b0},
    '{16'(3*W+1),   8'h38, G,     1'b1, 1'b0},
    '{16'(3*W+2),   8'h08, G,     1'b1, 1'b0},
    '{16'(3*W+3),   8'h88, G,     1'b1, 1'b1},
    '{16'(3*W+4),   8'h88, G,     1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  ctl;
  logic [31:0] gate;
  logic        busy, done;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  core_pwrup_seq #(.CLK_FREQ_HZ(FREQ), .WAIT_US(WUS), .GATE_CNT(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .core_ctl_o(ctl), .gate_ctl_o(gate), .busy_o(busy), .done_o(done)
  );

  function automatic string row_req(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] e_ctl, logic [31:0] e_gate,
                       logic e_busy, logic e_done);
    n_cmp++;
    if (ctl !== e_ctl || gate !== e_gate || busy !== e_busy || done !== e_done) begin
      n_bad++;
      $display("FAIL %s: actual ctl=%h gate=%h busy=%b done=%b expected ctl=%h gate=%h busy=%b done=%b",
               req, ctl, gate, busy, done, e_ctl, e_gate, e_busy, e_done);
    end
    n_cmp++;
    if ((ctl & 8'h44) != 8'h00) begin
      n_bad++;
      $display("FAIL R9: actual ctl=%h expected bits 2,6 low", ctl);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Walk the table from a start raised at the current negedge.
  task automatic run_seq(string tag, bit inject);
    int prev = -1;
    start = 1'b1;
    for (int i = 0; i < NROWS; i++) begin
      repeat (int'(ROWS[i].n) - prev) step();
      prev = int'(ROWS[i].n);
      check({tag, "/", row_req(i)}, ROWS[i].ctl, ROWS[i].gate, ROWS[i].busy, ROWS[i].done);
      if (inject && i == 4) start = 1'b1;  // R10: start while busy
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 8'h33, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) step();
    check("R1", 8'h33, 32'h0, 1'b0, 1'b0);

    run_seq("R2", 1'b0);
    run_seq("R10_R11", 1'b1);
    repeat (5) step();
    check("R8", 8'h88, G, 1'b0, 1'b0);

    start = 1'b1;
    repeat (50) step();
    rst_n = 1'b0;
    #1;
    check("R12", 8'h33, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) step();
    check("R12", 8'h33, 32'h0, 1'b0, 1'b0);
    run_seq("R12", 1'b0);

    finished = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual run still active expected completion");
      report();
    end
  end

endmodule